// File: doc/BRIEF.md
# Error-feedback word-length reducer

This block shortens signed PCM samples (20 bits in, 16 bits out by default) and shapes the noise that truncation creates. The sample itself passes to the quantizer without any filtering. Only the truncation error is filtered: it goes through a three-tap FIR and is added back to later samples. As a result, the error spectrum can be moved away from a band of interest even when the stream is not oversampled. The block can therefore run at the base sample rate for in-band shaping, or on an oversampled stream.

Optional triangular-density dither can be added just ahead of the truncation point. It is the difference of two uniform values, each one output LSB wide, taken from two independent shift-register generators. The dither spans two output LSBs in total and whitens the requantization error.

Each accepted sample produces one output sample a single clock later. Cycles without a valid sample leave the whole state untouched. The output saturates to the signed output range, and the error stored on a clipped sample is limited so that the loop stays bounded.

Top module: `wlr_noise_shaper`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_data` is 0 until the first valid sample. The three stored errors start at 0, and generator A starts at seed 16'hACE1 and generator B at seed 16'h5A3C.
- R2: `out_valid` equals `in_valid` delayed by one clock. The output for a sample accepted at one edge appears after that same edge.
- R3: The input is not filtered. With all stored errors 0 and dither off, the output is floor(x/16), where x is the signed input and 16 = 2^(IN_W-OUT_W).
- R4: The quantizer input is w = x + fb + d, where fb is the feedback term and d the dither. The output is y = floor(w/16), and the new error is w - 16*y, which lies in 0..15 when y is not clipped.
- R5: The feedback is fb = floor((C0*e1 + C1*e2 + C2*e3)/2^4), with e1 the newest stored error. The defaults are C0=32, C1=-16, C2=0. On each valid sample the error history shifts, so e3 takes e2, e2 takes e1 and e1 takes the new error.
- R6: A y above 32767 is output as 32767, and a y below -32768 is output as -32768.
- R7: On a clipped sample, the stored error is w - 16*y_out limited to the range -16..+16.
- R8: With `dither_en`=1, d = a[3:0] - b[3:0], where a and b are the current generator states. Each generator is a 16-bit left-shifting register whose new bit 0 is s[15]^s[13]^s[12]^s[10]. Both generators step on every valid sample whether or not dither is on. With `dither_en`=0, d = 0.
- R9: When `in_valid`=0, `in_data` and `dither_en` have no effect: `out_data` holds and no internal state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dither_en | input | 1 | Adds dither to the current sample when 1 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OUT_W | Signed shortened sample |

## Verification
Every accepted sample yields its output one clock after the edge that accepts it. Its error reaches the output through the feedback term on the next accepted sample, and the sample after that, no matter how many idle cycles lie in between. The bench drives inputs on the falling edge and keeps a behavioural model with a three-deep error history and two generator states. It compares `out_valid` and `out_data` on the following falling edge, so each compare sees exactly one register stage. Runs of clipped samples, mixed idle cycles and switching dither on and off show the history and generator timing directly at the output.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
  // Quantizer outcome for one sample
  typedef enum logic [1:0] {
    Q_IN_RANGE = 2'd0,
    Q_CLIP_HI  = 2'd1,
    Q_CLIP_LO  = 2'd2
  } qstat_e;

  localparam int unsigned LFSR_W    = 16;
  localparam logic [15:0] LFSR_TAPS = 16'hB400; // bits 15,13,12,10
endpackage

// File: rtl/wlr_lfsr.sv
module wlr_lfsr #(
  parameter int unsigned W        = 16,
  parameter logic [W-1:0] SEED    = '1,
  parameter logic [W-1:0] TAPS    = '1,
  parameter int unsigned OUT_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [OUT_BITS-1:0] value
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         new_bit;

  always_comb begin
    new_bit = ^(state_q & TAPS);
    state_d = state_q;
    if (adv) begin
      state_d = {state_q[W-2:0], new_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign value = state_q[OUT_BITS-1:0];
endmodule

// File: rtl/wlr_err_filter.sv
module wlr_err_filter #(
  parameter int unsigned ERR_W = 6,
  parameter int unsigned CW    = 8,
  parameter int unsigned CF    = 4,
  parameter int unsigned NTAP  = 3,
  parameter logic [NTAP*CW-1:0] COEFS = '0,
  localparam int unsigned PROD_W = CW + ERR_W,
  localparam int unsigned ACC_W  = PROD_W + $clog2(NTAP) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic signed [ERR_W-1:0] err_in,
  output logic signed [ACC_W-1:0] fb_out
);
  logic signed [ERR_W-1:0]  hist_q [NTAP];
  logic signed [ERR_W-1:0]  hist_d [NTAP];
  logic signed [PROD_W-1:0] prod   [NTAP];
  logic signed [ACC_W-1:0]  acc;

  // Newest error sits in slot 0 and meets coefficient 0
  always_comb begin
    for (int k = 0; k < NTAP; k++) begin
      hist_d[k] = hist_q[k];
    end
    if (shift_en) begin
      hist_d[0] = err_in;
      for (int k = 1; k < NTAP; k++) begin
        hist_d[k] = hist_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) begin
        hist_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NTAP; k++) begin
        hist_q[k] <= hist_d[k];
      end
    end
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam logic [CW-1:0] CK = COEFS[g*CW +: CW];
    logic [PROD_W-1:0] ca;
    logic [PROD_W-1:0] ha;
    assign ca = {{ERR_W{CK[CW-1]}}, CK};
    assign ha = {{CW{hist_q[g][ERR_W-1]}}, hist_q[g]};
    assign prod[g] = $signed(ca * ha);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) begin
      acc = acc + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end
  end

  assign fb_out = acc >>> CF;
endmodule

// File: rtl/wlr_quantizer.sv
module wlr_quantizer
  import wlr_pkg::*;
#(
  parameter int unsigned SUM_W = 23,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned DROP  = 4,
  localparam int unsigned ERR_W = DROP + 2
) (
  input  logic signed [SUM_W-1:0] w_in,
  output logic signed [OUT_W-1:0] y_out,
  output logic signed [ERR_W-1:0] err_out,
  output qstat_e                  stat
);
  localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'((2**(OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] Y_MIN = ~Y_MAX;
  localparam logic signed [SUM_W-1:0] E_HI  = SUM_W'(2**DROP);
  localparam logic signed [SUM_W-1:0] E_LO  = -E_HI;

  logic signed [SUM_W-1:0] y_full;
  logic signed [SUM_W-1:0] y_sat;
  logic signed [SUM_W-1:0] err_raw;

  always_comb begin
    y_full = w_in >>> DROP;
    if (y_full > Y_MAX) begin
      y_sat = Y_MAX;
      stat  = Q_CLIP_HI;
    end else if (y_full < Y_MIN) begin
      y_sat = Y_MIN;
      stat  = Q_CLIP_LO;
    end else begin
      y_sat = y_full;
      stat  = Q_IN_RANGE;
    end
    err_raw = w_in - (y_sat <<< DROP);
    unique case (stat)
      Q_CLIP_HI: err_out = E_HI[ERR_W-1:0];
      Q_CLIP_LO: err_out = (err_raw < E_LO) ? E_LO[ERR_W-1:0] : err_raw[ERR_W-1:0];
      default:   err_out = {{(ERR_W-DROP){1'b0}}, w_in[DROP-1:0]};
    endcase
  end

  assign y_out = y_sat[OUT_W-1:0];
endmodule

// File: rtl/wlr_noise_shaper.sv
module wlr_noise_shaper
  import wlr_pkg::*;
#(
  parameter int unsigned IN_W   = 20,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned CW     = 8,
  parameter int unsigned CF     = 4,
  parameter int          C0     = 32,
  parameter int          C1     = -16,
  parameter int          C2     = 0,
  parameter logic [15:0] SEED_A = 16'hACE1,
  parameter logic [15:0] SEED_B = 16'h5A3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dither_en,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int unsigned DROP   = IN_W - OUT_W;
  localparam int unsigned ERR_W  = DROP + 2;
  localparam int unsigned NTAP   = 3;
  localparam int unsigned PROD_W = CW + ERR_W;
  localparam int unsigned FB_W   = PROD_W + $clog2(NTAP) + 1;
  localparam int unsigned DITH_W = DROP + 2;
  localparam int unsigned BIG_W  = (IN_W > FB_W) ? IN_W : FB_W;
  localparam int unsigned SUM_W  = BIG_W + 3;
  localparam logic [NTAP*CW-1:0] COEF_VEC = {CW'(C2), CW'(C1), CW'(C0)};
  localparam logic [16*2-1:0]    SEEDS    = {SEED_B, SEED_A};

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Dither sources
  logic [DROP-1:0] unif [2];
  for (genvar g = 0; g < 2; g++) begin : g_src
    wlr_lfsr #(
      .W       (LFSR_W),
      .SEED    (SEEDS[g*16 +: 16]),
      .TAPS    (LFSR_TAPS),
      .OUT_BITS(DROP)
    ) i_lfsr (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .adv  (in_valid),
      .value(unif[g])
    );
  end

  logic signed [DITH_W-1:0] dither;
  always_comb begin
    dither = '0;
    if (dither_en) begin
      dither = $signed({2'b00, unif[0]}) - $signed({2'b00, unif[1]});
    end
  end

  // Error feedback filter
  logic signed [ERR_W-1:0] err_new;
  logic signed [FB_W-1:0]  fb;
  wlr_err_filter #(
    .ERR_W(ERR_W),
    .CW   (CW),
    .CF   (CF),
    .NTAP (NTAP),
    .COEFS(COEF_VEC)
  ) i_filt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .shift_en(in_valid),
    .err_in  (err_new),
    .fb_out  (fb)
  );

  // Quantizer input: unfiltered sample plus feedback plus dither
  logic signed [SUM_W-1:0] w_sum;
  always_comb begin
    w_sum = $signed({{(SUM_W-IN_W){in_data[IN_W-1]}}, in_data})
          + $signed({{(SUM_W-FB_W){fb[FB_W-1]}}, fb})
          + $signed({{(SUM_W-DITH_W){dither[DITH_W-1]}}, dither});
  end

  logic signed [OUT_W-1:0] y_q;
  qstat_e                  qstat;
  wlr_quantizer #(
    .SUM_W(SUM_W),
    .OUT_W(OUT_W),
    .DROP (DROP)
  ) i_quant (
    .w_in   (w_sum),
    .y_out  (y_q),
    .err_out(err_new),
    .stat   (qstat)
  );

  // Output stage
  logic             out_valid_d;
  logic [OUT_W-1:0] out_data_d;
  always_comb begin
    out_valid_d = in_valid;
    out_data_d  = out_data;
    if (in_valid) begin
      out_data_d = y_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_data  <= out_data_d;
    end
  end
endmodule

// File: rtl/wlr_checker.sv
module wlr_checker
  import wlr_pkg::*;
#(
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned ERR_W  = 6,
  parameter int unsigned DITH_W = 6
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     in_valid,
  input logic                     dither_en,
  input logic                     out_valid,
  input logic [OUT_W-1:0]         out_data,
  input logic signed [ERR_W-1:0]  err_new,
  input logic signed [DITH_W-1:0] dither,
  input qstat_e                   qstat
);
  localparam int DROP = ERR_W - 2;
  localparam int LIM  = 2**DROP;
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_data));
  a_r4_err_normal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && qstat == Q_IN_RANGE) |-> (err_new >= 0 && int'(err_new) < LIM));
  a_r7_err_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> (int'(err_new) <= LIM && int'(err_new) >= -LIM));
  a_r6_clip_hi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && qstat == Q_CLIP_HI) |=> out_data == OUT_MAX);
  a_r6_clip_lo: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && qstat == Q_CLIP_LO) |=> out_data == OUT_MIN);
  a_r8_dither_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dither_en |-> dither == 0);
  a_r8_dither_span: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(dither) < LIM && int'(dither) > -LIM));
endmodule

bind wlr_noise_shaper wlr_checker #(
  .OUT_W (OUT_W),
  .ERR_W (ERR_W),
  .DITH_W(DITH_W)
) i_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .in_valid  (in_valid),
  .dither_en (dither_en),
  .out_valid (out_valid),
  .out_data  (out_data),
  .err_new   (err_new),
  .dither    (dither),
  .qstat     (qstat)
);

// File: tb/test_wlr_noise_shaper.sv
module test_wlr_noise_shaper;
  localparam int C0 = 32, C1 = -16, C2 = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dither_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int          m_e1 = 0, m_e2 = 0, m_e3 = 0;
  logic [15:0] m_a = 16'hACE1, m_b = 16'h5A3C;
  int          exp_out = 0;
  bit          exp_valid = 0;

  always #10 clk = ~clk;

  wlr_noise_shaper i_wlr_noise_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .dither_en(dither_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic model(input bit v, input logic [19:0] x, input bit den);
    int d, fb, w, yf, ys, e;
    bit clip;
    if (v) begin
      d  = den ? (int'(m_a[3:0]) - int'(m_b[3:0])) : 0;
      fb = (C0 * m_e1 + C1 * m_e2 + C2 * m_e3) >>> 4;
      w  = int'($signed(x)) + fb + d;
      yf = w >>> 4;
      clip = 1'b1;
      if (yf > 32767) ys = 32767;
      else if (yf < -32768) ys = -32768;
      else begin ys = yf; clip = 1'b0; end
      e = w - ys * 16;
      if (clip) begin
        if (e > 16) e = 16;
        if (e < -16) e = -16;
      end
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = e;
      m_a = lfsr_next(m_a); m_b = lfsr_next(m_b);
      exp_out = ys;
    end
    exp_valid = v;
  endtask

  // one clock: drive at falling edge, compare at next falling edge
  task automatic step(input bit v, input logic [19:0] x, input bit den, input string req);
    in_valid  = v;
    in_data   = x;
    dither_en = den;
    model(v, x, den);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == exp_valid, req, "out_valid", int'(out_valid), int'(exp_valid));
    check(int'($signed(out_data)) == exp_out, req, "out_data",
          int'($signed(out_data)), exp_out);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    @(negedge clk);
    // R1: during reset
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_data == 16'd0, "R1", "out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_data == 16'd0, "R1", "out_data after reset", int'(out_data), 0);

    // R3: exact multiples keep the error history at zero
    step(1, 20'd0, 0, "R3");
    step(1, 20'(16 * 100), 0, "R3");
    step(1, 20'(-16 * 5000), 0, "R3");
    step(1, 20'(16 * 32767), 0, "R3");
    step(1, 20'(-16 * 32768), 0, "R3");

    // R4: single small residue then zero input reveals the stored error
    step(1, 20'd7, 0, "R4");
    step(1, 20'd0, 0, "R4");
    step(1, 20'd0, 0, "R4");
    step(1, 20'd0, 0, "R4");

    // R5: shaping under a ramp and random samples
    for (int i = 0; i < 20; i++) step(1, 20'(i * 37 - 300), 0, "R5");
    for (int i = 0; i < 30; i++) step(1, 20'($urandom), 0, "R5");

    // R2 and R9: idle cycles with garbage on the input
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 1) step(0, 20'($urandom), (i % 2) == 0, "R9");
      else            step(1, 20'($urandom), 0, "R2");
    end
    step(0, 20'hFFFFF, 1, "R9");
    step(0, 20'h80000, 1, "R9");
    step(1, 20'd5, 0, "R9");

    // R6 then R7: positive and negative overload, then recovery
    for (int i = 0; i < 6; i++) step(1, 20'h7FFFF, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 20'd0, 0, "R7");
    for (int i = 0; i < 6; i++) step(1, 20'h80000, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, 20'd0, 0, "R7");

    // R8: dither on, then off with advanced generators
    for (int i = 0; i < 40; i++) step(1, 20'($urandom), 1, "R8");
    for (int i = 0; i < 6; i++)  step(1, 20'(i * 16), 1, "R8");
    for (int i = 0; i < 10; i++) step(1, 20'($urandom), 0, "R8");
    for (int i = 0; i < 8; i++)  step(i % 2 == 0, 20'($urandom), 1, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule